// File: doc/BRIEF.md
# Encoded Arithmetic, Logic and Shift Function Unit

This block is the combinational compute stage of a small register-transfer datapath. It takes two operand buses, `a_bus` and `b_bus`, and a 4-bit operation code `op`. It returns one result word and four status flags. The operation code selects one of three engines:

- **Adder.** It forms `A + Y + carry-in`. `Y` is one of four functions of `B`.
- **Bitwise logic.** It combines `A` and `B`, or inverts `A`.
- **Single-place shifter.** It acts on `B` only.

The surrounding control fetches the operands and writes the result back. The flags feed branch decisions.

The block holds no state. A new operand or code changes the result and the flags in the same cycle. The one code left unassigned (`1111`) gives a defined, all-quiet output: a zero result with every flag clear.

Top module: `func_unit`

## Requirements
- R1: For codes `0op[2:1]op[0]` (op[3]=0), the result is `(A + Y + op[0]) mod 2^W`. `Y` is chosen by op[2:1]: 00 gives all zeros, 01 gives B, 10 gives the bitwise complement of B, 11 gives all ones. This yields the eight operations:
  - 0000 = A
  - 0001 = A+1
  - 0010 = A+B
  - 0011 = A+B+1
  - 0100 = A+~B
  - 0101 = A−B
  - 0110 = A−1
  - 0111 = A
- R2: For codes 0000–0111, `cout` is the carry out of the W-bit addition `A + Y + op[0]`.
- R3: For codes 0000–0111, `ovf` is 1 exactly when A and Y have equal sign bits and the result's sign bit differs from them.
- R4: The logic codes are:
  - 1000 gives A AND B.
  - 1001 gives A OR B.
  - 1010 gives A XOR B.
  - 1011 gives NOT A.
- R5: The shift codes are:
  - 1100 passes B unchanged.
  - 1101 shifts B right by one place, with 0 entering the MSB.
  - 1110 shifts B left by one place, with 0 entering the LSB.
- R6: For codes 1000–1110, `cout` and `ovf` are 0 whatever the operands.
- R7: For codes 0000–1110, `neg` equals the result's MSB. `zero` is 1 exactly when the result is all zeros.
- R8: Code 1111 drives the result to 0 and `ovf`, `cout`, `neg` and `zero` all to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_bus | input | W | First operand |
| b_bus | input | W | Second operand; also the shifter's source |
| op | input | 4 | Operation code |
| res | output | W | Result word |
| ovf | output | 1 | Two's-complement overflow (adder codes only) |
| cout | output | 1 | Carry out (adder codes only) |
| neg | output | 1 | Sign of the result |
| zero | output | 1 | Result is all zeros |

## Verification
Every output of this block is due in the same cycle as its stimulus, since there is no register between the inputs and any result or flag. The driver applies operands and a code just after a rising edge and queues the expected word and flags. The monitor pops the queue at the following falling edge, half a period later, by which time the combinational paths have settled. Each entry is therefore compared against the stimulus that produced it and no other. Every one of the sixteen codes is swept against operand pairs chosen to hit carry-out, signed overflow, a zero result and sign changes.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [1:0] {
        Y_ZERO = 2'b00,
        Y_B    = 2'b01,
        Y_NOTB = 2'b10,
        Y_ONES = 2'b11
    } ysel_t;

    typedef enum logic [1:0] {
        UNIT_ARITH,
        UNIT_LOGIC,
        UNIT_SHIFT,
        UNIT_NONE
    } unit_t;

    typedef struct packed {
        unit_t      unit;
        ysel_t      ysel;
        logic       cin;
        logic [1:0] sub;
    } fu_ctrl_t;

endpackage

// File: rtl/fu_decode.sv
module fu_decode
    import fu_pkg::*;
(
    input  logic [3:0] op,
    output fu_ctrl_t   ctrl
);

    always_comb begin
        ctrl.ysel = ysel_t'(op[2:1]);
        ctrl.cin  = op[0];
        ctrl.sub  = op[1:0];
        unique case (op[3:2])
            2'b00, 2'b01: ctrl.unit = UNIT_ARITH;
            2'b10:        ctrl.unit = UNIT_LOGIC;
            default:      ctrl.unit = (op[1:0] == 2'b11) ? UNIT_NONE : UNIT_SHIFT;
        endcase
    end

endmodule

// File: rtl/fu_arith.sv
module fu_arith
    import fu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  ysel_t        ysel,
    input  logic         cin,
    output logic [W-1:0] g,
    output logic         carry,
    output logic         ovf
);

    localparam int MSB = W - 1;

    logic [W-1:0] y;
    logic [W:0]   full;
    logic [MSB:0] low;

    always_comb begin
        unique case (ysel)
            Y_ZERO:  y = '0;
            Y_B:     y = b;
            Y_NOTB:  y = ~b;
            default: y = '1;
        endcase
    end

    assign full  = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};
    assign g     = full[W-1:0];
    assign carry = full[W];

    // carry into the sign position: add the lower bits only
    assign low   = {1'b0, a[MSB-1:0]} + {1'b0, y[MSB-1:0]} + {{MSB{1'b0}}, cin};
    assign ovf   = carry ^ low[MSB];

endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] out
);

    always_comb begin
        unique case (sel)
            2'b00:   out = a & b;
            2'b01:   out = a | b;
            2'b10:   out = a ^ b;
            default: out = ~a;
        endcase
    end

endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    input  logic         fill_r,
    input  logic         fill_l,
    output logic [W-1:0] out
);

    always_comb begin
        unique case (sel)
            2'b00:   out = b;
            2'b01:   out = {fill_r, b[W-1:1]};
            2'b10:   out = {b[W-2:0], fill_l};
            default: out = '0;
        endcase
    end

endmodule

// File: rtl/func_unit.sv
module func_unit
    import fu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_bus,
    input  logic [W-1:0] b_bus,
    input  logic [3:0]   op,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         cout,
    output logic         neg,
    output logic         zero
);

    localparam int MSB = W - 1;

    fu_ctrl_t     ctrl;
    logic [W-1:0] g_arith;
    logic [W-1:0] g_logic;
    logic [W-1:0] g_shift;
    logic         c_arith;
    logic         v_arith;

    fu_decode u_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    fu_arith #(.W(W)) u_arith (
        .a     (a_bus),
        .b     (b_bus),
        .ysel  (ctrl.ysel),
        .cin   (ctrl.cin),
        .g     (g_arith),
        .carry (c_arith),
        .ovf   (v_arith)
    );

    fu_logic #(.W(W)) u_logic (
        .a   (a_bus),
        .b   (b_bus),
        .sel (ctrl.sub),
        .out (g_logic)
    );

    fu_shift #(.W(W)) u_shift (
        .b      (b_bus),
        .sel    (ctrl.sub),
        .fill_r (1'b0),
        .fill_l (1'b0),
        .out    (g_shift)
    );

    always_comb begin
        res  = '0;
        ovf  = 1'b0;
        cout = 1'b0;
        neg  = 1'b0;
        zero = 1'b0;
        unique case (ctrl.unit)
            UNIT_ARITH: begin
                res  = g_arith;
                ovf  = v_arith;
                cout = c_arith;
            end
            UNIT_LOGIC: res = g_logic;
            UNIT_SHIFT: res = g_shift;
            default:    res = '0;
        endcase
        if (ctrl.unit != UNIT_NONE) begin
            neg  = res[MSB];
            zero = (res == '0);
        end
    end

endmodule

// File: rtl/fu_checker.sv
module fu_checker #(
    parameter int W = 8
) (
    input logic [W-1:0] a_bus,
    input logic [W-1:0] b_bus,
    input logic [3:0]   op,
    input logic [W-1:0] res,
    input logic         ovf,
    input logic         cout,
    input logic         neg,
    input logic         zero
);

    always_comb begin
        // R1
        pass_a_chk: assert (op != 4'b0000 || res == a_bus);
        // R4
        invert_a_chk: assert (op != 4'b1011 || res == ~a_bus);
        // R5
        pass_b_chk: assert (op != 4'b1100 || res == b_bus);
        // R6
        no_arith_flags_chk: assert (!op[3] || op == 4'b1111 || (!cout && !ovf));
        // R7
        zero_flag_chk: assert (op == 4'b1111 || zero == (res == '0));
        // R7
        sign_flag_chk: assert (op == 4'b1111 || neg == res[W-1]);
        // R8
        unused_code_chk: assert (op != 4'b1111 || (res == '0 && !ovf && !cout && !neg && !zero));
    end

endmodule

bind func_unit fu_checker #(.W(W)) u_fu_checker (
    .a_bus (a_bus),
    .b_bus (b_bus),
    .op    (op),
    .res   (res),
    .ovf   (ovf),
    .cout  (cout),
    .neg   (neg),
    .zero  (zero)
);

// File: tb/func_unit_bench.sv
module func_unit_bench;

    localparam int W        = 8;
    localparam int CLK_HALF = 5;
    localparam int WD_LIMIT = 5000;

    typedef struct {
        logic [W-1:0] res;
        logic         ovf, cout, neg, zero;
        logic [3:0]   op;
        logic [W-1:0] a, b;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_bus = '0;
    logic [W-1:0] b_bus = '0;
    logic [3:0]   op = 4'b0000;
    logic [W-1:0] res;
    logic         ovf, cout, neg, zero;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #CLK_HALF clk = ~clk;

    func_unit #(.W(W)) u_func_unit (
        .a_bus (a_bus),
        .b_bus (b_bus),
        .op    (op),
        .res   (res),
        .ovf   (ovf),
        .cout  (cout),
        .neg   (neg),
        .zero  (zero)
    );

    // independent reference built from the requirements
    function automatic exp_t model(logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b);
        exp_t e;
        logic [W-1:0] y;
        logic [W:0]   s;
        e.op = c; e.a = a; e.b = b;
        e.ovf = 1'b0; e.cout = 1'b0;
        if (!c[3]) begin
            // R1 R2 R3: adder codes
            case (c[2:1])
                2'b00: y = '0;
                2'b01: y = b;
                2'b10: y = ~b;
                default: y = '1;
            endcase
            s      = {1'b0, a} + {1'b0, y} + (W+1)'(c[0]);
            e.res  = s[W-1:0];
            e.cout = s[W];
            e.ovf  = (a[W-1] == y[W-1]) && (s[W-1] != a[W-1]);
            e.tag  = "R1 R2 R3 R7";
        end else if (!c[2]) begin
            // R4
            case (c[1:0])
                2'b00: e.res = a & b;
                2'b01: e.res = a | b;
                2'b10: e.res = a ^ b;
                default: e.res = ~a;
            endcase
            e.tag = "R4 R6 R7";
        end else if (c[1:0] != 2'b11) begin
            // R5
            case (c[1:0])
                2'b00: e.res = b;
                2'b01: e.res = b >> 1;
                default: e.res = b << 1;
            endcase
            e.tag = "R5 R6 R7";
        end else begin
            e.res = '0;
            e.tag = "R8";
        end
        if (c == 4'b1111) begin
            e.neg = 1'b0; e.zero = 1'b0;
        end else begin
            e.neg  = e.res[W-1];
            e.zero = (e.res == '0);
        end
        return e;
    endfunction

    task automatic apply(logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b);
        @(posedge clk);
        op = c; a_bus = a; b_bus = b;
        exp_q.push_back(model(c, a, b));
    endtask

    // monitor: results are due in the same cycle, sampled at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (res !== e.res || ovf !== e.ovf || cout !== e.cout ||
                    neg !== e.neg || zero !== e.zero) begin
                    n_fail++;
                    $display("FAIL %s op=%b a=%h b=%h: got res=%h v=%b c=%b n=%b z=%b, expected res=%h v=%b c=%b n=%b z=%b",
                             e.tag, e.op, e.a, e.b, res, ovf, cout, neg, zero,
                             e.res, e.ovf, e.cout, e.neg, e.zero);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: got running, expected finished");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] pa [10] = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h80, 8'h55, 8'h3C, 8'h01, 8'hA5, 8'h00};
        logic [W-1:0] pb [10] = '{8'h00, 8'h01, 8'h01, 8'h80, 8'h01, 8'hAA, 8'h0F, 8'hFF, 8'h5A, 8'hFF};
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // idle state: zero operands, code 0000 -> zero result, zero flag set (R1, R7)
        apply(4'b0000, '0, '0);
        for (int p = 0; p < 10; p++) begin
            for (int c = 0; c < 16; c++) begin
                apply(4'(c), pa[p], pb[p]);
            end
        end
        // boundary cases: R3 overflow on A-1 at most-negative, R2 carry on A+1 at all-ones
        apply(4'b0110, 8'h80, 8'h00);
        apply(4'b0001, 8'hFF, 8'h00);
        // R5 edge bits shifted out, R8 with nonzero operands
        apply(4'b1101, 8'h00, 8'h01);
        apply(4'b1110, 8'h00, 8'h80);
        apply(4'b1111, 8'hFF, 8'hFF);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule